// File: doc/BRIEF.md
# Credit-Based Event Destination Manager

This block chooses which event-builder node receives each new event in a network-based readout system. Each builder node sends single-cycle request pulses to say it can take another event. Every pulse gives that node one credit in a per-node table. When the trigger side offers a new event number, the manager picks a node that holds at least one credit, taking the nodes in rotation. It spends one of that node's credits and presents an assignment on a valid/ready output.

The assignment can be used in two ways, and a mode input selects between them. In push mode the readout side takes the chosen node index as the place to send the event fragments. In pull mode the manager also drives a one-hot fetch command to the chosen builder, which then requests the data itself. If no node holds a credit, the manager lowers its new-event ready and holds the event until a credit arrives. The data movement itself happens outside this block.

Top module: `evt_dest_mgr`

## Requirements
- R1: After reset every credit count is zero, no assignment is valid, `evt_ready_o` is low and `asg_fetch_o` is all zero.
- R2: Each cycle with `req_i[n]` high adds one credit to node n. The count saturates at its maximum of 15 for the default 4-bit width, so further requests have no effect.
- R3: An event goes only to a node with a nonzero credit count. While every count is zero, `evt_ready_o` stays low and no event is accepted.
- R4: Each accepted event removes exactly one credit from the node it was assigned to.
- R5: The search for a destination starts at the node after the last one assigned, wrapping from the highest index to node 0, and starts at node 0 after reset. Nodes without credit are skipped.
- R6: If a node gets a request in the same cycle that an event is assigned to it, its credit count is unchanged.
- R7: While `asg_valid_o` is high and `asg_ready_i` is low, the node index and event number hold steady and `evt_ready_o` is low. An event is accepted in the same cycle that the pending assignment drains.
- R8: With `mode_pull_i` low (push), `asg_pull_o` is 0 and `asg_fetch_o` is all zero. With `mode_pull_i` high (pull), `asg_pull_o` is 1 and, while the assignment is valid, `asg_fetch_o` has only the bit of the chosen node set.
- R9: A change of `mode_pull_i` while an assignment is pending has no effect until the output has drained. The new mode applies from the second cycle after the drain.
- R10: A node holding k credits can receive k events in a row while the other nodes hold none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NODES | Per-node capacity request pulses |
| mode_pull_i | input | 1 | 0 = push mode, 1 = pull mode |
| evt_valid_i | input | 1 | New event offered |
| evt_num_i | input | EW | Event number of the offered event |
| evt_ready_o | output | 1 | Event accepted when high with valid |
| asg_valid_o | output | 1 | Assignment present |
| asg_ready_i | input | 1 | Assignment taken by the consumer |
| asg_node_o | output | NW | Chosen destination node |
| asg_evt_o | output | EW | Event number of the assignment |
| asg_pull_o | output | 1 | Mode that applies to the assignment |
| asg_fetch_o | output | NODES | One-hot fetch command in pull mode |

## Verification
The credit counts cannot be read, so a wrong count shows up later at the ports. A missing credit makes `evt_ready_o` fall one event too early. An extra credit sends one more event to the same node than it asked for, and this appears in the cycle after the event that should have been refused. A wrong rotation pointer gives the wrong `asg_node_o` on the very next assignment. Saturation and the same-cycle case are therefore checked by counting how many events in a row one node absorbs before ready drops.

// File: rtl/evt_dest_mgr.sv
module evt_dest_mgr #(
  parameter int NODES = 4,
  parameter int CW    = 4,
  parameter int EW    = 16,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] req_i,
  input  logic             mode_pull_i,
  input  logic             evt_valid_i,
  input  logic [EW-1:0]    evt_num_i,
  output logic             evt_ready_o,
  output logic             asg_valid_o,
  input  logic             asg_ready_i,
  output logic [NW-1:0]    asg_node_o,
  output logic [EW-1:0]    asg_evt_o,
  output logic             asg_pull_o,
  output logic [NODES-1:0] asg_fetch_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [NW-1:0] LAST = NW'(NODES - 1);

  logic [CW-1:0]    cred [NODES];
  logic [NODES-1:0] has;
  logic [NW-1:0]    ptr, sel;
  logic             found, acc, mode_q;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NODES; i++) begin
      int j;
      j = (int'(ptr) + i) % NODES;
      if (!found && has[j]) begin
        found = 1'b1;
        sel   = NW'(j);
      end
    end
  end

  assign evt_ready_o = found && (!asg_valid_o || asg_ready_i);
  assign acc         = evt_valid_i && evt_ready_o;
  assign asg_pull_o  = mode_q;
  assign asg_fetch_o = (asg_valid_o && mode_q) ? (NODES'(1) << asg_node_o) : '0;

  for (genvar g = 0; g < NODES; g++) begin : g_cred
    logic up, dn;
    assign has[g] = |cred[g];
    assign up     = req_i[g] && (cred[g] != CMAX);
    assign dn     = acc && (sel == NW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)               cred[g] <= '0;
      else if (up && !dn)       cred[g] <= cred[g] + 1'b1;
      else if (dn && !req_i[g]) cred[g] <= cred[g] - 1'b1;
    end

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cred[g] == CMAX && !dn) |=> cred[g] == CMAX); // R2
    AST_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !req_i[g]) |=> cred[g] == $past(cred[g]) - 1'b1); // R4
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && req_i[g]) |=> $stable(cred[g])); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr         <= '0;
      asg_valid_o <= 1'b0;
      asg_node_o  <= '0;
      asg_evt_o   <= '0;
      mode_q      <= 1'b0;
    end else begin
      if (!asg_valid_o) mode_q <= mode_pull_i;
      if (acc) begin
        asg_valid_o <= 1'b1;
        asg_node_o  <= sel;
        asg_evt_o   <= evt_num_i;
        ptr         <= (sel == LAST) ? '0 : sel + 1'b1;
      end else if (asg_ready_i) begin
        asg_valid_o <= 1'b0;
      end
    end
  end

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid_o && !asg_ready_i) |=> asg_valid_o && $stable(asg_node_o) && $stable(asg_evt_o)); // R7
  AST_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> asg_valid_o); // R3
  AST_FETCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(asg_fetch_o)); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid_o && $past(asg_valid_o)) |-> $stable(asg_pull_o)); // R9
endmodule

// File: tb/sim_evt_dest_mgr.sv
module sim_evt_dest_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic        mode = 1'b0;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_num = '0;
  logic        evt_ready, asg_valid, asg_pull;
  logic        asg_ready = 1'b1;
  logic [1:0]  asg_node;
  logic [15:0] asg_evt;
  logic [3:0]  asg_fetch;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  evt_dest_mgr u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_pull_i(mode),
    .evt_valid_i(evt_valid), .evt_num_i(evt_num), .evt_ready_o(evt_ready),
    .asg_valid_o(asg_valid), .asg_ready_i(asg_ready), .asg_node_o(asg_node),
    .asg_evt_o(asg_evt), .asg_pull_o(asg_pull), .asg_fetch_o(asg_fetch)
  );

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) req = m;
      @(negedge clk) req = '0;
    end
  endtask

  task automatic do_evt(input logic [15:0] n, input int node, input logic [3:0] m, input string r);
    @(negedge clk);
    evt_valid = 1'b1; evt_num = n; req = m;
    chk({r, " ready"}, evt_ready, 1);
    @(negedge clk);
    evt_valid = 1'b0; req = '0;
    chk({r, " valid"}, asg_valid, 1);
    chk({r, " node"}, asg_node, node);
    chk({r, " evt"}, asg_evt, n);
  endtask

  task automatic dry(input string r);
    @(negedge clk);
    chk({r, " dry ready"}, evt_ready, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", evt_ready, 0);
    chk("R1 valid", asg_valid, 0);
    chk("R1 fetch", asg_fetch, 0);
  endtask

  task automatic t_rotate;
    pulse(4'hF, 1);
    for (int i = 0; i < 4; i++) do_evt(16'h10 + 16'(i), i, 4'h0, "R5 rotate");
    dry("R4 consume");
  endtask

  task automatic t_skip;
    pulse(4'b0101, 1);
    do_evt(16'h20, 0, 4'h0, "R3 skip");
    do_evt(16'h21, 2, 4'h0, "R5 skip");
    dry("R3 empty");
  endtask

  task automatic t_multi;
    pulse(4'b1000, 3);
    for (int i = 0; i < 3; i++) do_evt(16'h30 + 16'(i), 3, 4'h0, "R10 multi");
    dry("R10 used");
  endtask

  task automatic t_sat;
    pulse(4'b0010, 18);
    for (int i = 0; i < 15; i++) do_evt(16'h40 + 16'(i), 1, 4'h0, "R2 sat");
    dry("R2 sat limit");
  endtask

  task automatic t_same;
    pulse(4'b0010, 1);
    do_evt(16'h50, 1, 4'b0010, "R6 same");
    do_evt(16'h51, 1, 4'h0, "R6 kept");
    dry("R6 after");
  endtask

  task automatic t_hold;
    pulse(4'b0001, 2);
    @(negedge clk) asg_ready = 1'b0;
    do_evt(16'h77, 0, 4'h0, "R7 first");
    evt_valid = 1'b1; evt_num = 16'h78;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 ready low", evt_ready, 0);
      chk("R7 node", asg_node, 0);
      chk("R7 evt", asg_evt, 16'h77);
    end
    asg_ready = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R7 drain valid", asg_valid, 1);
    chk("R7 drain evt", asg_evt, 16'h78);
    @(negedge clk);
  endtask

  task automatic t_mode;
    pulse(4'b0100, 2);
    @(negedge clk) asg_ready = 1'b0;
    do_evt(16'h90, 2, 4'h0, "R8 push");
    chk("R8 push pull", asg_pull, 0);
    chk("R8 push fetch", asg_fetch, 0);
    mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 frozen pull", asg_pull, 0);
    chk("R9 frozen fetch", asg_fetch, 0);
    asg_ready = 1'b1;
    repeat (2) @(negedge clk);
    do_evt(16'h91, 2, 4'h0, "R8 pull");
    chk("R8 pull flag", asg_pull, 1);
    chk("R8 pull fetch", asg_fetch, 4'b0100);
    mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rotate;
    t_skip;
    t_multi;
    t_sat;
    t_same;
    t_hold;
    t_mode;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule